// File: doc/BRIEF.md
# Tagged Pipelined Execution Unit Shell

This block wraps a fully pipelined operation of fixed latency. It lets that operation sit beside other long-latency units on one shared register-file write port. The scheduler drives the same operand buses to every unit and raises `issue_en` only for the unit it selects. An accepted operation enters a stage chain `LAT` entries long. The chain moves forward every cycle. Each stage holds the operation's result, its destination register and the sequence tag the scheduler gave it. The datapath is a stand-in multiply-accumulate: `a*b + a`, truncated to the register width.

Results leave the chain into a small holding queue with as many slots as the chain has stages. The queue presents its oldest live entry on the write port unless `freeze` is high. `freeze` is how the arbiter keeps the unit off the shared port. `ready` tells the scheduler whether another operation fits: it fits when the work in the chain plus the work in the queue is below the queue size. A mispredicted branch is handled with `kill_en` and a tag. Every in-flight result whose tag is at or after that tag, in wrapping order, is discarded. This happens inside the unit, so decode does not have to stall.

A three-state controller tracks how much work is present. The states are:
- ST_IDLE: no work.
- ST_FLIGHT: work only in the stage chain.
- ST_BACKLOG: the holding queue is not empty.

The transitions are:
- *launch*: ST_IDLE to ST_FLIGHT.
- *spill*: into ST_BACKLOG from either other state.
- *settle*: ST_BACKLOG to ST_FLIGHT.
- *drain*: to ST_IDLE from either busy state.

The state moves on the occupancy of the next cycle. `running` is high in every state except ST_IDLE.

Top module: `tagx_exec_unit`

## Requirements
- R1: An operation is accepted only on a clock edge where both `issue_en` and `ready` are high. With `issue_en` low, or `ready` low, the operand, register and tag inputs leave no trace on the outputs.
- R2: An operation accepted at edge E is presented on the write port after edge E+LAT (LAT=8 by default) when nothing holds it back. `res_data` equals the low 32 bits of `opnd_a*opnd_b + opnd_a`, and `res_reg` and `res_tag` equal the values given at issue.
- R3: `ready` is high exactly when the valid stage entries plus the occupied queue slots number fewer than LAT. LAT back-to-back issues under `freeze` therefore drop `ready`, and no result is lost.
- R4: `running` is high from the edge after an accepted issue until the edge on which the last result leaves the unit.
- R5: While `freeze` is high, `res_valid` stays low and results wait in the queue. When `freeze` falls, they are released.
- R6: Results are released in issue order, and `res_valid` is high for exactly one cycle per result.
- R7: A `kill_en` pulse with tag K removes every operation still in the stage chain whose tag T satisfies (T−K) mod 64 < 32. Such operations are never released.
- R8: The same kill rule removes matching results that are already waiting in the queue.
- R9: Tag comparison wraps. With tags 62, 63, 0, 1 in flight, a kill with tag 0 removes only 0 and 1.
- R10: If the kill hits the result currently presented, `res_valid` drops in that same cycle, and that result is never released.
- R11: Synchronous active-high `rst` empties the unit. After reset, `running`=0, `res_valid`=0 and `ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issue_en | input | 1 | Select this unit to take the operand buses |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| dst_reg | input | 5 | Destination register of the operation |
| issue_tag | input | 6 | Sequence tag of the operation |
| freeze | input | 1 | Hold results off the write port |
| kill_en | input | 1 | Discard in-flight work from `kill_tag` onward |
| kill_tag | input | 6 | First tag of the squashed path |
| ready | output | 1 | Another operation can be accepted |
| running | output | 1 | Work is in flight |
| res_valid | output | 1 | A result is on the write port this cycle |
| res_data | output | 32 | Result value |
| res_reg | output | 5 | Destination register of the result |
| res_tag | output | 6 | Tag of the result |

## Verification
The bench fills the unit under `freeze` until `ready` falls. It then offers one more operation and checks that exactly LAT results come out, in order. A queue sized too small would lose results here, and a wrong ready rule would leak a ninth result. Kill tests cover three cases: entries in the stage chain, entries waiting behind `freeze`, and the tag counter wrapping from 63 to 0. A comparison without wrapping would spare tags 0 and 1 or wrongly kill 62 and 63. A kill aimed at the result already on the port must pull `res_valid` low in that same cycle. A design that let release win would write a squashed result.

// File: rtl/tagx_pkg.sv
`timescale 1ns/1ps
package tagx_pkg;

    // Work-presence regimes of the unit
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_FLIGHT  = 2'd1,
        ST_BACKLOG = 2'd2
    } unit_state_e;

    // True when tag lies at or after ref_tag in wrapping program order,
    // using the low `width` bits and a half-range window.
    function automatic logic tag_at_or_after(input logic [7:0] tag,
                                             input logic [7:0] ref_tag,
                                             input int unsigned width);
        logic [7:0] mask;
        logic [7:0] diff;
        logic [7:0] half;
        mask = 8'((9'd1 << width) - 9'd1);
        half = 8'(9'd1 << (width - 1));
        diff = (tag - ref_tag) & mask;
        return diff < half;
    endfunction

endpackage

// File: rtl/tagx_pipe.sv
`timescale 1ns/1ps
module tagx_pipe #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned TAG_W  = 6,
    parameter int unsigned LAT    = 8,
    localparam int unsigned CNT_W = $clog2(LAT + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_v,
    input  logic [DATA_W-1:0] in_data,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic              kill_en,
    input  logic [TAG_W-1:0]  kill_tag,
    output logic              out_v,
    output logic [DATA_W-1:0] out_data,
    output logic [ADDR_W-1:0] out_addr,
    output logic [TAG_W-1:0]  out_tag,
    output logic [CNT_W-1:0]  cnt,
    output logic [CNT_W-1:0]  cnt_nx
);
    import tagx_pkg::*;

    logic [LAT-1:0]    v_q;
    logic [LAT-1:0]    v_nx;
    logic [LAT-1:0]    hit;
    logic [DATA_W-1:0] d_q [LAT];
    logic [ADDR_W-1:0] a_q [LAT];
    logic [TAG_W-1:0]  t_q [LAT];

    // Which stages the kill command reaches this cycle
    always_comb begin
        for (int i = 0; i < int'(LAT); i++) begin
            hit[i] = kill_en && tag_at_or_after(8'(t_q[i]), 8'(kill_tag), TAG_W);
        end
    end

    // Valid bits advance; a killed entry is dropped as it moves on
    always_comb begin
        v_nx[0] = in_v;
        for (int i = 1; i < int'(LAT); i++) begin
            v_nx[i] = v_q[i-1] && !hit[i-1];
        end
    end

    genvar g;
    generate
        for (g = 0; g < int'(LAT); g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    v_q[g] <= 1'b0;
                end else begin
                    v_q[g] <= v_nx[g];
                end
            end
            if (g == 0) begin : g_head
                always_ff @(posedge clk) begin
                    d_q[g] <= in_data;
                    a_q[g] <= in_addr;
                    t_q[g] <= in_tag;
                end
            end else begin : g_body
                always_ff @(posedge clk) begin
                    d_q[g] <= d_q[g-1];
                    a_q[g] <= a_q[g-1];
                    t_q[g] <= t_q[g-1];
                end
                // R7: a killed entry never reaches the next stage
                a_r7_pipe_squash: assert property (@(posedge clk) disable iff (rst)
                    (kill_en && v_q[g-1] &&
                     tag_at_or_after(8'(t_q[g-1]), 8'(kill_tag), TAG_W)) |=> !v_q[g]);
            end
        end
    endgenerate

    always_comb begin
        out_v    = v_q[LAT-1] && !hit[LAT-1];
        out_data = d_q[LAT-1];
        out_addr = a_q[LAT-1];
        out_tag  = t_q[LAT-1];
    end

    always_comb begin
        cnt    = '0;
        cnt_nx = '0;
        for (int i = 0; i < int'(LAT); i++) begin
            cnt    = cnt + CNT_W'(v_q[i]);
            cnt_nx = cnt_nx + CNT_W'(v_nx[i]);
        end
    end

endmodule

// File: rtl/tagx_outq.sv
`timescale 1ns/1ps
module tagx_outq #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned TAG_W  = 6,
    parameter int unsigned DEPTH  = 8,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1),
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [TAG_W-1:0]  push_tag,
    input  logic              freeze,
    input  logic              kill_en,
    input  logic [TAG_W-1:0]  kill_tag,
    output logic              fire,
    output logic [DATA_W-1:0] head_data,
    output logic [ADDR_W-1:0] head_addr,
    output logic [TAG_W-1:0]  head_tag,
    output logic [CNT_W-1:0]  cnt,
    output logic [CNT_W-1:0]  cnt_nx
);
    import tagx_pkg::*;

    logic [DEPTH-1:0]  sv_q;
    logic [DEPTH-1:0]  s_hit;
    logic [DATA_W-1:0] sd_q [DEPTH];
    logic [ADDR_W-1:0] sa_q [DEPTH];
    logic [TAG_W-1:0]  st_q [DEPTH];
    logic [PTR_W-1:0]  rd_q;
    logic [PTR_W-1:0]  wr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              head_live;
    logic              pop;

    function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        for (int i = 0; i < int'(DEPTH); i++) begin
            s_hit[i] = kill_en && tag_at_or_after(8'(st_q[i]), 8'(kill_tag), TAG_W);
        end
    end

    // Head is live when occupied, not killed earlier and not killed now
    always_comb begin
        head_live = (cnt_q != '0) && sv_q[rd_q] && !s_hit[rd_q];
        fire      = head_live && !freeze;
        // a dead head is dropped even under freeze
        pop       = (cnt_q != '0) && (!freeze || !head_live);
        head_data = sd_q[rd_q];
        head_addr = sa_q[rd_q];
        head_tag  = st_q[rd_q];
        cnt       = cnt_q;
        cnt_nx    = cnt_q + CNT_W'(push) - CNT_W'(pop);
    end

    genvar g;
    generate
        for (g = 0; g < int'(DEPTH); g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst) begin
                    sv_q[g] <= 1'b0;
                end else if (push && wr_q == PTR_W'(g)) begin
                    sv_q[g] <= 1'b1;
                end else if (s_hit[g]) begin
                    sv_q[g] <= 1'b0;
                end
            end
            always_ff @(posedge clk) begin
                if (push && wr_q == PTR_W'(g)) begin
                    sd_q[g] <= push_data;
                    sa_q[g] <= push_addr;
                    st_q[g] <= push_tag;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_q <= ptr_step(wr_q);
            if (pop)  rd_q <= ptr_step(rd_q);
            cnt_q <= cnt_nx;
        end
    end

    // R3: the ready rule must never let the queue overflow
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        push |-> (cnt_q < CNT_W'(DEPTH) || pop));

endmodule

// File: rtl/tagx_ctrl.sv
`timescale 1ns/1ps
module tagx_ctrl #(
    parameter int unsigned DEPTH  = 8,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] pipe_cnt,
    input  logic [CNT_W-1:0] q_cnt,
    input  logic [CNT_W-1:0] pipe_cnt_nx,
    input  logic [CNT_W-1:0] q_cnt_nx,
    output logic             ready,
    output logic             running
);
    import tagx_pkg::*;

    unit_state_e state_q;
    unit_state_e state_nx;
    logic [CNT_W:0] load;

    // Next regime from next-cycle occupancy
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (q_cnt_nx != '0)         state_nx = ST_BACKLOG; // spill
                else if (pipe_cnt_nx != '0) state_nx = ST_FLIGHT;  // launch
            end
            ST_FLIGHT: begin
                if (q_cnt_nx != '0)         state_nx = ST_BACKLOG; // spill
                else if (pipe_cnt_nx == '0) state_nx = ST_IDLE;    // drain
            end
            ST_BACKLOG: begin
                if (q_cnt_nx == '0) begin
                    if (pipe_cnt_nx != '0)  state_nx = ST_FLIGHT;  // settle
                    else                    state_nx = ST_IDLE;    // drain
                end
            end
            default:                        state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_nx;
    end

    always_comb begin
        load    = {1'b0, pipe_cnt} + {1'b0, q_cnt};
        ready   = load < (CNT_W + 1)'(DEPTH);
        running = (state_q != ST_IDLE);
    end

    // R4: any stored work implies running
    a_r4_running_busy: assert property (@(posedge clk) disable iff (rst)
        (pipe_cnt != '0 || q_cnt != '0) |-> running);

endmodule

// File: rtl/tagx_exec_unit.sv
`timescale 1ns/1ps
module tagx_exec_unit #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned TAG_W  = 6,
    parameter int unsigned LAT    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_en,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [ADDR_W-1:0] dst_reg,
    input  logic [TAG_W-1:0]  issue_tag,
    input  logic              freeze,
    input  logic              kill_en,
    input  logic [TAG_W-1:0]  kill_tag,
    output logic              ready,
    output logic              running,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data,
    output logic [ADDR_W-1:0] res_reg,
    output logic [TAG_W-1:0]  res_tag
);
    localparam int unsigned QDEPTH = LAT;
    localparam int unsigned CNT_W  = $clog2(QDEPTH + 1);

    logic              accept;
    logic [DATA_W-1:0] mac;
    logic              p_out_v;
    logic [DATA_W-1:0] p_out_data;
    logic [ADDR_W-1:0] p_out_addr;
    logic [TAG_W-1:0]  p_out_tag;
    logic [CNT_W-1:0]  p_cnt;
    logic [CNT_W-1:0]  p_cnt_nx;
    logic [CNT_W-1:0]  q_cnt;
    logic [CNT_W-1:0]  q_cnt_nx;

    // Placeholder datapath: multiply-accumulate stand-in
    always_comb begin
        accept = issue_en && ready;
        mac    = opnd_a * opnd_b + opnd_a;
    end

    tagx_pipe #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .TAG_W(TAG_W), .LAT(LAT)
    ) pipe_i (
        .clk(clk), .rst(rst),
        .in_v(accept), .in_data(mac), .in_addr(dst_reg), .in_tag(issue_tag),
        .kill_en(kill_en), .kill_tag(kill_tag),
        .out_v(p_out_v), .out_data(p_out_data), .out_addr(p_out_addr),
        .out_tag(p_out_tag), .cnt(p_cnt), .cnt_nx(p_cnt_nx)
    );

    tagx_outq #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .TAG_W(TAG_W), .DEPTH(QDEPTH)
    ) outq_i (
        .clk(clk), .rst(rst),
        .push(p_out_v), .push_data(p_out_data), .push_addr(p_out_addr),
        .push_tag(p_out_tag), .freeze(freeze),
        .kill_en(kill_en), .kill_tag(kill_tag),
        .fire(res_valid), .head_data(res_data), .head_addr(res_reg),
        .head_tag(res_tag), .cnt(q_cnt), .cnt_nx(q_cnt_nx)
    );

    tagx_ctrl #(
        .DEPTH(QDEPTH)
    ) ctrl_i (
        .clk(clk), .rst(rst),
        .pipe_cnt(p_cnt), .q_cnt(q_cnt),
        .pipe_cnt_nx(p_cnt_nx), .q_cnt_nx(q_cnt_nx),
        .ready(ready), .running(running)
    );

    // R11: reset leaves the unit empty on the following cycle
    a_r11_reset_clear: assert property (@(posedge clk)
        rst |=> (!running && !res_valid && ready));

    // R9: tag window must cover every slot that can be outstanding
    initial begin
        a_r9_tag_window: assert ((QDEPTH <= (1 << (TAG_W - 1))) && TAG_W <= 8);
    end

endmodule

// File: tb/tagx_exec_unit_tb.sv
`timescale 1ns/1ps
module tagx_exec_unit_tb_top;

    localparam int LAT = 8;
    localparam int NV  = 6;

    // {a[74:43], b[42:11], reg[10:6], tag[5:0]}
    localparam logic [74:0] VEC [NV] = '{
        {32'h0000_0003, 32'h0000_0005, 5'd1,  6'd1},
        {32'h0000_0000, 32'h0000_007B, 5'd2,  6'd2},
        {32'hFFFF_FFFF, 32'h0000_0002, 5'd31, 6'd3},
        {32'h0000_2710, 32'h0000_2710, 5'd9,  6'd4},
        {32'h8000_0000, 32'h8000_0000, 5'd7,  6'd5},
        {32'h1234_5678, 32'h0000_0009, 5'd0,  6'd6}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue_en = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [4:0]  dst_reg = '0;
    logic [5:0]  issue_tag = '0;
    logic        freeze = 1'b0;
    logic        kill_en = 1'b0;
    logic [5:0]  kill_tag = '0;
    logic        ready, running, res_valid;
    logic [31:0] res_data;
    logic [4:0]  res_reg;
    logic [5:0]  res_tag;

    int total = 0;
    int fails = 0;
    int cyc = 0;
    int ngot = 0;
    logic [31:0] got_data [32];
    logic [4:0]  got_reg [32];
    logic [5:0]  got_tag [32];
    int          got_cyc [32];
    int          iss_cyc [NV];

    always #2.5 clk = ~clk;

    tagx_exec_unit dut_i (
        .clk(clk), .rst(rst), .issue_en(issue_en), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .dst_reg(dst_reg), .issue_tag(issue_tag),
        .freeze(freeze), .kill_en(kill_en), .kill_tag(kill_tag),
        .ready(ready), .running(running), .res_valid(res_valid),
        .res_data(res_data), .res_reg(res_reg), .res_tag(res_tag)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    // Sample once per cycle just after the falling edge, then move on
    task automatic collect(input int n);
        for (int k = 0; k < n; k++) begin
            #1;
            if (res_valid && ngot < 32) begin
                got_data[ngot] = res_data;
                got_reg[ngot]  = res_reg;
                got_tag[ngot]  = res_tag;
                got_cyc[ngot]  = cyc;
                ngot++;
            end
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic drive(input bit en, input logic [31:0] a, input logic [31:0] b,
                         input logic [4:0] r, input logic [5:0] t);
        issue_en  = en;
        opnd_a    = a;
        opnd_b    = b;
        dst_reg   = r;
        issue_tag = t;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        // R11: reset state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        check(running == 1'b0, "R11", "running after reset", running, 0);
        check(res_valid == 1'b0, "R11", "res_valid after reset", res_valid, 0);
        check(ready == 1'b1, "R11", "ready after reset", ready, 1);
        @(negedge clk);

        // R2/R6: vector table walked back to back
        ngot = 0;
        for (int i = 0; i < NV; i++) begin
            drive(1'b1, VEC[i][74:43], VEC[i][42:11], VEC[i][10:6], VEC[i][5:0]);
            iss_cyc[i] = cyc;
            collect(1);
        end
        drive(1'b0, '0, '0, '0, '0);
        collect(LAT + 4);
        check(ngot == NV, "R6", "result count", ngot, NV);
        for (int i = 0; i < NV && i < ngot; i++) begin
            logic [31:0] ea;
            logic [31:0] eb;
            logic [31:0] ex;
            ea = VEC[i][74:43];
            eb = VEC[i][42:11];
            ex = ea * eb + ea;
            check(got_data[i] == ex, "R2", "data", got_data[i], ex);
            check(got_reg[i] == VEC[i][10:6] && got_tag[i] == VEC[i][5:0], "R2",
                  "reg/tag", {got_reg[i], got_tag[i]}, VEC[i][10:0]);
            check(got_cyc[i] == iss_cyc[i] + LAT + 1, "R2", "latency",
                  got_cyc[i] - iss_cyc[i], LAT + 1);
        end

        // R4: running follows in-flight work
        #1;
        check(running == 1'b0, "R4", "running idle", running, 0);
        @(negedge clk);
        drive(1'b1, 32'd2, 32'd3, 5'd4, 6'd8);
        @(negedge clk);
        drive(1'b0, '0, '0, '0, '0);
        #1;
        check(running == 1'b1, "R4", "running after issue", running, 1);
        @(negedge clk);
        ngot = 0;
        collect(LAT + 3);
        #1;
        check(running == 1'b0, "R4", "running after drain", running, 0);

        // R1: enable low leaves no trace
        ngot = 0;
        drive(1'b0, 32'd7, 32'd7, 5'd3, 6'd9);
        collect(LAT + 4);
        drive(1'b0, '0, '0, '0, '0);
        check(ngot == 0, "R1", "releases without enable", ngot, 0);
        check(running == 1'b0, "R1", "running without enable", running, 0);

        // R5: freeze holds results, release keeps order
        ngot = 0;
        freeze = 1'b1;
        drive(1'b1, 32'd1, 32'd1, 5'd10, 6'd30);
        collect(1);
        drive(1'b1, 32'd2, 32'd2, 5'd11, 6'd31);
        collect(1);
        drive(1'b0, '0, '0, '0, '0);
        collect(LAT + 4);
        check(ngot == 0, "R5", "releases under freeze", ngot, 0);
        freeze = 1'b0;
        collect(4);
        check(ngot == 2, "R5", "released after freeze", ngot, 2);
        check(got_tag[0] == 6'd30 && got_tag[1] == 6'd31, "R6", "order after freeze",
              {got_tag[0], got_tag[1]}, {6'd30, 6'd31});
        check(got_cyc[1] == got_cyc[0] + 1, "R6", "one pulse per result",
              got_cyc[1] - got_cyc[0], 1);

        // R3: fill under freeze until ready falls
        ngot = 0;
        freeze = 1'b1;
        for (int i = 0; i < LAT; i++) begin
            if (i == LAT - 1) begin
                #1;
                check(ready == 1'b1, "R3", "ready before last slot", ready, 1);
            end
            drive(1'b1, 32'(i), 32'd1, 5'(i), 6'(40 + i));
            collect(1);
        end
        #1;
        check(ready == 1'b0, "R3", "ready when full", ready, 0);
        drive(1'b1, 32'd99, 32'd1, 5'd20, 6'd50);
        collect(1);
        drive(1'b0, '0, '0, '0, '0);
        collect(LAT + 2);
        check(ngot == 0, "R3", "held while full", ngot, 0);
        freeze = 1'b0;
        collect(LAT + 4);
        check(ngot == LAT, "R3", "results after full", ngot, LAT);
        for (int i = 0; i < LAT && i < ngot; i++) begin
            check(got_tag[i] == 6'(40 + i), "R1", "no trace of refused issue",
                  got_tag[i], 40 + i);
        end

        // R7: kill inside the stage chain
        ngot = 0;
        for (int i = 0; i < 4; i++) begin
            drive(1'b1, 32'd5, 32'd5, 5'd1, 6'(10 + i));
            collect(1);
        end
        drive(1'b0, '0, '0, '0, '0);
        collect(2);
        kill_en = 1'b1;
        kill_tag = 6'd12;
        collect(1);
        kill_en = 1'b0;
        collect(LAT + 4);
        check(ngot == 2, "R7", "survivors of pipe kill", ngot, 2);
        check(got_tag[0] == 6'd10 && got_tag[1] == 6'd11, "R7", "surviving tags",
              {got_tag[0], got_tag[1]}, {6'd10, 6'd11});

        // R9: kill across the tag wrap
        ngot = 0;
        for (int i = 0; i < 4; i++) begin
            drive(1'b1, 32'd1, 32'd2, 5'd2, 6'(62 + i));
            collect(1);
        end
        drive(1'b0, '0, '0, '0, '0);
        collect(1);
        kill_en = 1'b1;
        kill_tag = 6'd0;
        collect(1);
        kill_en = 1'b0;
        collect(LAT + 4);
        check(ngot == 2, "R9", "survivors of wrap kill", ngot, 2);
        check(got_tag[0] == 6'd62 && got_tag[1] == 6'd63, "R9", "wrap tags",
              {got_tag[0], got_tag[1]}, {6'd62, 6'd63});

        // R8: kill results waiting behind freeze
        ngot = 0;
        freeze = 1'b1;
        for (int i = 0; i < 3; i++) begin
            drive(1'b1, 32'd3, 32'd3, 5'd6, 6'(5 + i));
            collect(1);
        end
        drive(1'b0, '0, '0, '0, '0);
        collect(LAT + 3);
        kill_en = 1'b1;
        kill_tag = 6'd6;
        collect(1);
        kill_en = 1'b0;
        freeze = 1'b0;
        collect(6);
        check(ngot == 1, "R8", "survivors of queue kill", ngot, 1);
        check(got_tag[0] == 6'd5, "R8", "queue survivor tag", got_tag[0], 5);

        // R10: kill beats release on the presented head
        ngot = 0;
        drive(1'b1, 32'd4, 32'd4, 5'd8, 6'd20);
        @(negedge clk);
        drive(1'b0, '0, '0, '0, '0);
        repeat (LAT) @(negedge clk);
        #1;
        check(res_valid == 1'b1 && res_tag == 6'd20, "R10", "head presented",
              {res_valid, res_tag}, {1'b1, 6'd20});
        kill_en = 1'b1;
        kill_tag = 6'd20;
        #1;
        check(res_valid == 1'b0, "R10", "same-cycle kill", res_valid, 0);
        @(negedge clk);
        kill_en = 1'b0;
        collect(LAT);
        check(ngot == 0, "R10", "killed head never released", ngot, 0);
        check(running == 1'b0, "R10", "idle after kill", running, 0);

        summary();
    end

endmodule